// File: doc/BRIEF.md
# FSK Carrier-Detect Qualifier

This block turns the raw "energy present" flag from the FSK band filter of a caller-ID receiver into a confirmed carrier status. The carrier is confirmed only after the flag has stayed high for a programmable on-guard time. It is reported lost only after the flag has stayed low for a separate, shorter off-guard time. A run that is broken inside either window starts that window again from zero.

An optional improved qualification adds a second stage after the on-guard time. A number of channel-seizure bit periods must follow, and each one must show a change of the demodulated bit. This stage is bypassed while the line is off hook, because a call-waiting burst carries no seizure pattern. With the defaults (1 MHz clock) the on-guard time is 26.4 ms and the off-guard time is 8.8 ms. The improved path adds 10 bit periods of 833 cycles, about 34.7 ms in total.

Each confirmation or loss sets a sticky interrupt request together with a cause bit. An acknowledge pulse clears the request. A command bit gates the demodulated data toward the byte assembler, so that speech or tone energy is not passed on as data.

Top module: `fsk_cd_qual`

## Requirements
- R1: After reset, `carrier_o`, `irq_o` and `evt_cause_o` are 0 and `demod_bit_o` is 1.
- R2: In normal mode (`mode_improved`=0), `carrier_o` goes to 1 on the clock edge that samples `lvl_raw`=1 for the ON_CYC-th consecutive time.
- R3: A low sample of `lvl_raw` while the carrier is not yet confirmed restarts the on-guard count from zero.
- R4: With `mode_improved`=1 and `mode_offhook`=0, the on-guard time is followed by a seizure stage. A bit tick falls on every BIT_CYC-th edge of that stage. `carrier_o` rises on the tick that completes SEIZE_BITS consecutive ticks at which `rx_bit` differs from its value at the previous tick, or at stage entry for the first tick.
- R5: A tick without a change of `rx_bit` restarts the seizure count. A low `lvl_raw` during the seizure stage returns the block to the on-guard wait with a zero count.
- R6: With `mode_offhook`=1, the seizure stage is skipped and the carrier is confirmed after the on-guard time alone, even when `mode_improved`=1.
- R7: Once the carrier is confirmed, `carrier_o` goes to 0 on the edge that samples `lvl_raw`=0 for the OFF_CYC-th consecutive time. Any high sample restarts this count.
- R8: A confirmation sets `irq_o`=1 and `evt_cause_o`=1. A loss sets `irq_o`=1 and `evt_cause_o`=0. `irq_ack` clears `irq_o` at the next edge. An event on the same edge takes priority over the acknowledge.
- R9: `demod_en_o` is 1 only when `demod_en_cmd`=1 and the block is in the seizure stage or has a confirmed carrier. `demod_bit_o` equals `rx_bit` while `demod_en_o`=1 and is 1 (mark) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_raw | input | 1 | Raw amplitude-present flag from the band filter |
| rx_bit | input | 1 | Demodulated data bit |
| mode_improved | input | 1 | 1 selects the seizure-bit qualification |
| mode_offhook | input | 1 | 1 when off hook; bypasses the seizure stage |
| demod_en_cmd | input | 1 | Command bit allowing demodulated data to pass |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| carrier_o | output | 1 | Confirmed carrier status |
| irq_o | output | 1 | Sticky interrupt request |
| evt_cause_o | output | 1 | Cause of the last event: 1 confirm, 0 loss |
| demod_en_o | output | 1 | Demodulator enable |
| demod_bit_o | output | 1 | Gated demodulated bit, mark when disabled |

## Verification
The hardest situation to reach is the seizure stage: a flag that is already qualified, followed by a chain of bit ticks in which exactly one tick lacks a change of the data bit. Only then can a restart of the count be told apart from a confirmation that was merely late. The stimulus reaches it by keeping `lvl_raw` high through the on-guard time and then driving `rx_bit` as a square wave locked to the bit period. `rx_bit` is then held steady across one tick and the square wave is restarted. Further runs drop `lvl_raw` in the middle of the stage, and repeat the same sequence with `mode_offhook` set to show the bypass.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
    typedef enum logic [1:0] {
        CD_WAIT  = 2'd0,
        CD_SEIZE = 2'd1,
        CD_HOLD  = 2'd2
    } cd_state_e;

    typedef struct packed {
        cd_state_e state;
        logic      irq;
        logic      cause;
    } cd_regs_t;
endpackage

// File: rtl/cdq_run_timer.sv
module cdq_run_timer #(
    parameter int LIM = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int W = (LIM < 2) ? 1 : $clog2(LIM + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = run && (cnt_q == W'(LIM - 1));
        cnt_d = (run && !hit) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cdq_seize_qual.sv
module cdq_seize_qual #(
    parameter int BIT_CYC    = 833,
    parameter int SEIZE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_bit,
    output logic done
);
    localparam int TW = (BIT_CYC < 2) ? 1 : $clog2(BIT_CYC + 1);
    localparam int NW = (SEIZE_BITS < 2) ? 1 : $clog2(SEIZE_BITS + 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic          ref_bit;
        logic [NW-1:0] nbits;
    } sq_regs_t;

    sq_regs_t r_d, r_q;
    logic     tick_now;
    logic     toggled;

    always_comb begin
        r_d      = r_q;
        tick_now = active && (r_q.tick == TW'(BIT_CYC - 1));
        toggled  = (rx_bit != r_q.ref_bit);
        done     = tick_now && toggled && (r_q.nbits == NW'(SEIZE_BITS - 1));
        if (!active) begin
            r_d.tick    = '0;
            r_d.ref_bit = rx_bit;
            r_d.nbits   = '0;
        end else if (tick_now) begin
            r_d.tick    = '0;
            r_d.ref_bit = rx_bit;
            r_d.nbits   = (toggled && !done) ? r_q.nbits + 1'b1 : '0;
        end else begin
            r_d.tick = r_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/fsk_cd_qual.sv
module fsk_cd_qual #(
    parameter int ON_CYC     = 26400,
    parameter int OFF_CYC    = 8800,
    parameter int BIT_CYC    = 833,
    parameter int SEIZE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_raw,
    input  logic rx_bit,
    input  logic mode_improved,
    input  logic mode_offhook,
    input  logic demod_en_cmd,
    input  logic irq_ack,
    output logic carrier_o,
    output logic irq_o,
    output logic evt_cause_o,
    output logic demod_en_o,
    output logic demod_bit_o
);
    import cdq_pkg::*;

    cd_regs_t r_d, r_q;
    logic     on_hit, off_hit, seize_done;
    logic     ev_conf, ev_loss;

    cdq_run_timer #(.LIM(ON_CYC)) u_on_tmr (
        .clk(clk), .rst_n(rst_n),
        .run(r_q.state == CD_WAIT && lvl_raw),
        .hit(on_hit)
    );

    cdq_run_timer #(.LIM(OFF_CYC)) u_off_tmr (
        .clk(clk), .rst_n(rst_n),
        .run(r_q.state == CD_HOLD && !lvl_raw),
        .hit(off_hit)
    );

    cdq_seize_qual #(.BIT_CYC(BIT_CYC), .SEIZE_BITS(SEIZE_BITS)) u_seize (
        .clk(clk), .rst_n(rst_n),
        .active(r_q.state == CD_SEIZE),
        .rx_bit(rx_bit),
        .done(seize_done)
    );

    always_comb begin
        r_d     = r_q;
        ev_conf = 1'b0;
        ev_loss = 1'b0;
        case (r_q.state)
            CD_WAIT: if (on_hit) begin
                if (mode_improved && !mode_offhook) begin
                    r_d.state = CD_SEIZE;
                end else begin
                    r_d.state = CD_HOLD;
                    ev_conf   = 1'b1;
                end
            end
            CD_SEIZE: if (!lvl_raw) begin
                r_d.state = CD_WAIT;
            end else if (seize_done) begin
                r_d.state = CD_HOLD;
                ev_conf   = 1'b1;
            end
            CD_HOLD: if (off_hit) begin
                r_d.state = CD_WAIT;
                ev_loss   = 1'b1;
            end
            default: r_d.state = CD_WAIT;
        endcase
        if (ev_conf || ev_loss) begin
            r_d.irq   = 1'b1;
            r_d.cause = ev_conf;
        end else if (irq_ack) begin
            r_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: CD_WAIT, irq: 1'b0, cause: 1'b0};
        else        r_q <= r_d;
    end

    assign carrier_o   = (r_q.state == CD_HOLD);
    assign irq_o       = r_q.irq;
    assign evt_cause_o = r_q.cause;
    assign demod_en_o  = demod_en_cmd && (r_q.state != CD_WAIT);
    assign demod_bit_o = demod_en_o ? rx_bit : 1'b1;
endmodule

// File: rtl/cdq_chk.sv
module cdq_chk (
    input logic clk,
    input logic rst_n,
    input logic lvl_raw,
    input logic demod_en_cmd,
    input logic irq_ack,
    input logic carrier_o,
    input logic irq_o,
    input logic evt_cause_o,
    input logic demod_bit_o
);
    // R2
    rise_needs_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_o) |-> $past(lvl_raw));
    // R7
    fall_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_o) |-> !$past(lvl_raw));
    // R8
    confirm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_o) |-> (irq_o && evt_cause_o));
    // R8
    loss_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_o) |-> (irq_o && !evt_cause_o));
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ($stable(carrier_o) -> !irq_o));
    // R9
    gated_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !demod_en_cmd |-> demod_bit_o);
endmodule

bind fsk_cd_qual cdq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lvl_raw(lvl_raw), .demod_en_cmd(demod_en_cmd),
    .irq_ack(irq_ack), .carrier_o(carrier_o), .irq_o(irq_o),
    .evt_cause_o(evt_cause_o), .demod_bit_o(demod_bit_o)
);

// File: tb/sim_fsk_cd_qual.sv
module sim_fsk_cd_qual;
    localparam int ON  = 12;
    localparam int OFF = 6;
    localparam int BIT = 4;
    localparam int NSZ = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl_raw = 0, rx_bit = 0, mode_improved = 0, mode_offhook = 0;
    logic demod_en_cmd = 0, irq_ack = 0;
    logic carrier_o, irq_o, evt_cause_o, demod_en_o, demod_bit_o;

    always #4 clk = ~clk;

    fsk_cd_qual #(.ON_CYC(ON), .OFF_CYC(OFF), .BIT_CYC(BIT), .SEIZE_BITS(NSZ)) u0 (
        .clk(clk), .rst_n(rst_n), .lvl_raw(lvl_raw), .rx_bit(rx_bit),
        .mode_improved(mode_improved), .mode_offhook(mode_offhook),
        .demod_en_cmd(demod_en_cmd), .irq_ack(irq_ack),
        .carrier_o(carrier_o), .irq_o(irq_o), .evt_cause_o(evt_cause_o),
        .demod_en_o(demod_en_o), .demod_bit_o(demod_bit_o)
    );

    int vectors = 0, miscompares = 0, cyc = 0, tcount = 0;
    bit done_flag = 0;

    // behavioural reference: phase 0 waiting, 1 seizure, 2 carrier held
    int m_phase = 0, m_on = 0, m_off = 0, m_tick = 0, m_nsz = 0;
    bit m_ref = 0, m_irq = 0, m_cause = 0;

    always @(posedge clk) begin
        bit conf, loss;
        conf = 0; loss = 0;
        if (!rst_n) begin
            m_phase = 0; m_on = 0; m_off = 0; m_tick = 0; m_nsz = 0;
            m_ref = 0; m_irq = 0; m_cause = 0;
        end else begin
            if (m_phase == 0) begin
                if (lvl_raw) begin
                    m_on++;
                    if (m_on == ON) begin
                        m_on = 0;
                        if (mode_improved && !mode_offhook) begin
                            m_phase = 1; m_tick = 0; m_nsz = 0; m_ref = rx_bit;
                        end else begin
                            m_phase = 2; conf = 1;
                        end
                    end
                end else m_on = 0;
            end else if (m_phase == 1) begin
                if (!lvl_raw) m_phase = 0;
                else begin
                    m_tick++;
                    if (m_tick == BIT) begin
                        m_tick = 0;
                        if (rx_bit != m_ref) m_nsz++; else m_nsz = 0;
                        m_ref = rx_bit;
                        if (m_nsz == NSZ) begin m_phase = 2; conf = 1; end
                    end
                end
            end else begin
                if (!lvl_raw) begin
                    m_off++;
                    if (m_off == OFF) begin m_off = 0; m_phase = 0; loss = 1; end
                end else m_off = 0;
            end
            if (conf || loss) begin m_irq = 1; m_cause = conf; end
            else if (irq_ack) m_irq = 0;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit en;
            en = demod_en_cmd && (m_phase != 0);
            vectors++;
            chk("R2 R3 R4 R5 R6 R7 carrier_o", carrier_o, m_phase == 2);
            chk("R8 irq_o", irq_o, m_irq);
            chk("R8 evt_cause_o", evt_cause_o, m_cause);
            chk("R9 demod_en_o", demod_en_o, en);
            chk("R9 demod_bit_o", demod_bit_o, en ? rx_bit : 1'b1);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done_flag) begin
            done_flag = 1;
            miscompares++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // one cycle; rxm: 0 hold rx, 1 square wave locked to bit period
    task automatic step(logic lvl, int rxm, logic ack);
        @(posedge clk); #2;
        lvl_raw = lvl; irq_ack = ack;
        if (rxm == 1) rx_bit = ((tcount / BIT) % 2) != 0;
        tcount++;
    endtask

    task automatic steps(int n, logic lvl, int rxm);
        for (int i = 0; i < n; i++) step(lvl, rxm, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        vectors++;
        chk("R1 carrier_o", carrier_o, 1'b0);
        chk("R1 irq_o", irq_o, 1'b0);
        chk("R1 evt_cause_o", evt_cause_o, 1'b0);
        chk("R1 demod_bit_o", demod_bit_o, 1'b1);

        // R2 normal confirm, R9 gating with command on
        demod_en_cmd = 1;
        steps(ON + 2, 1, 1);
        step(1, 1, 1);          // R8 ack
        steps(3, 1, 1);
        // R7 loss with a restart in the middle
        steps(3, 0, 0);
        steps(1, 1, 0);
        steps(OFF + 2, 0, 0);
        // R3 drop during on-guard restarts
        steps(ON - 5, 1, 0);
        steps(1, 0, 0);
        steps(ON - 1, 1, 0);
        steps(3, 1, 0);
        steps(OFF + 1, 0, 0);
        step(0, 0, 1);
        // R4 improved mode with clean seizure pattern
        mode_improved = 1;
        tcount = 0;
        steps(ON + NSZ * BIT + 4, 1, 1);
        steps(OFF + 1, 0, 0);
        // R5 missing toggle restarts, then success
        steps(ON, 1, 0);
        steps(2 * BIT, 1, 0);       // rx held: no toggles
        tcount = 0;
        steps(NSZ * BIT + 6, 1, 1);
        steps(OFF + 1, 0, 0);
        // R5 drop during seizure returns to wait
        steps(ON + BIT, 1, 1);
        steps(1, 0, 1);
        steps(ON + NSZ * BIT + 4, 1, 1);
        // R9 command off while carrier held
        demod_en_cmd = 0;
        steps(6, 1, 1);
        demod_en_cmd = 1;
        steps(OFF + 1, 0, 0);
        // R6 off-hook bypass, R8 ack coinciding with confirm edge
        mode_offhook = 1;
        steps(ON - 1, 1, 0);
        step(1, 0, 1);
        steps(3, 1, 0);
        step(1, 0, 1);
        steps(OFF + 2, 0, 0);
        mode_offhook = 0; mode_improved = 0;
        steps(4, 0, 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule